// File: doc/BRIEF.md
# Byte-Wide Access Bridge for Three 16-bit Registers

This block sits between a bus master whose data path is only eight bits wide and a group of three 16-bit peripheral registers: one control word and two PWM data words. Because the master can only move one byte per access, the bridge keeps a single shared 8-bit holding register. With it, a 16-bit register is always updated in one step on a write and sampled in one step on a read, so the peripheral logic never sees a half-written value.

A write of the upper byte only parks that byte in the holding register. The following lower-byte write joins it with the new low byte and commits the full word. A read of the upper byte returns the live upper byte and at the same edge copies the live lower byte into the holding register. A following lower-byte read returns that captured byte. The master must access the upper byte first. The bridge neither detects nor repairs any other order. The holding register is shared by all three registers, so mixed accesses combine data across registers.

Top module: `wide_reg_bridge`

## Requirements
- R1: On synchronous active-high reset, all three registers, the holding register and the read data clear to zero.
- R2: Address decoding: `bus_addr[0]` selects the half (0 = upper byte, 1 = lower byte), and `bus_addr[2:1]` selects the register (0 = control, 1 = data A, 2 = data B, 3 = unused). A write to an upper byte changes only the holding register and leaves every register unchanged.
- R3: A write to a lower byte loads the addressed register with {holding byte, written byte}, visible on the register outputs one clock later.
- R4: The control register keeps only bits 2:0, and its bits 15:3 always read 0. Bit 2 enables channel A output, bit 1 inverts the output phase, and bit 0 selects a time step of two clock periods (1) or one (0). These bits also drive `ctrl_chan_a_en`, `ctrl_invert` and `ctrl_step_x2`.
- R5: A read of an upper byte puts the register's upper byte on `bus_rdata` one clock later and copies its lower byte into the holding register.
- R6: A read of a lower byte returns the holding register one clock later, not the register's live lower byte.
- R7: The holding register is shared: an upper-byte access to one register followed by a lower-byte access to another combines data from both.
- R8: `bus_rdata` is 0 in the clock after any cycle without an effective read. An upper read of index 3 returns 0 and clears the holding register. A lower write to index 3 changes no register.
- R9: When write and read strobes are asserted together, only the write takes effect, and `bus_rdata` is 0 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register index (bits 2:1) and byte half (bit 0) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Registered read data byte |
| ctrl_word | output | 16 | Control register value |
| data_a | output | 16 | PWM data register A |
| data_b | output | 16 | PWM data register B |
| ctrl_chan_a_en | output | 1 | Control bit 2: channel A output enable |
| ctrl_invert | output | 1 | Control bit 1: output phase inverted |
| ctrl_step_x2 | output | 1 | Control bit 0: time step of two clock periods |

## Verification
The assertions take the strobes and address as known values on every clock after reset, and treat a cycle with both strobes as a write. They assume no ordering between upper and lower accesses, since order is the master's duty. The stimulus drives all inputs at the falling edge, so they are steady at every rising edge. Alongside the directed sequences, it issues free-running accesses in any order, including cross-register, index 3 and simultaneous strobes, all of which the requirements define.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
    localparam int BYTE_W    = 8;
    localparam int WORD_W    = 2 * BYTE_W;
    localparam int IDX_W     = 2;
    localparam int ADDR_W    = IDX_W + 1;
    localparam int NUM_REGS  = 3;
    localparam int CTRL_IDX  = 0;
    localparam int CTRL_BITS = 3;

    typedef enum logic {
        HALF_UPPER = 1'b0,
        HALF_LOWER = 1'b1
    } half_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        half_e             half;
        logic [IDX_W-1:0]  idx;
        logic              valid;
        logic [BYTE_W-1:0] wdata;
    } bus_req_t;

    function automatic logic [WORD_W-1:0] reg_mask(input int which);
        logic [WORD_W-1:0] m;
        m = '1;
        if (which == CTRL_IDX) begin
            m = '0;
            for (int b = 0; b < CTRL_BITS; b++) m[b] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/wrb_decode.sv
module wrb_decode
    import wrb_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [BYTE_W-1:0] wdata,
    output bus_req_t          req
);
    always_comb begin
        req.wr    = wr;
        req.rd    = rd & ~wr;
        req.half  = half_e'(addr[0]);
        req.idx   = addr[ADDR_W-1:1];
        req.valid = ({1'b0, addr[ADDR_W-1:1]} < (IDX_W + 1)'(NUM_REGS));
        req.wdata = wdata;
    end
endmodule

// File: rtl/wrb_hold.sv
module wrb_hold
    import wrb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic [BYTE_W-1:0] live_low,
    output logic [BYTE_W-1:0] hold_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (req.wr && req.half == HALF_UPPER) begin
            hold_q <= req.wdata;
        end else if (req.rd && req.half == HALF_UPPER) begin
            hold_q <= req.valid ? live_low : '0;
        end
    end
endmodule

// File: rtl/wrb_regfile.sv
module wrb_regfile
    import wrb_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  bus_req_t                         req,
    input  logic [BYTE_W-1:0]                hold_q,
    output logic [NUM_REGS-1:0][WORD_W-1:0]  regs_q
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [WORD_W-1:0] MASK = reg_mask(g);
        logic commit;
        assign commit = req.wr && req.half == HALF_LOWER && req.valid
                        && req.idx == IDX_W'(g);
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[g] <= '0;
            end else if (commit) begin
                regs_q[g] <= {hold_q, req.wdata} & MASK;
            end
        end
    end
endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge
    import wrb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic [WORD_W-1:0] ctrl_word,
    output logic [WORD_W-1:0] data_a,
    output logic [WORD_W-1:0] data_b,
    output logic              ctrl_chan_a_en,
    output logic              ctrl_invert,
    output logic              ctrl_step_x2
);
    bus_req_t                        req;
    logic [BYTE_W-1:0]               hold_q;
    logic [NUM_REGS-1:0][WORD_W-1:0] regs_q;
    logic [WORD_W-1:0]               sel_word;

    wrb_decode u_decode (
        .addr  (bus_addr),
        .wr    (bus_wr),
        .rd    (bus_rd),
        .wdata (bus_wdata),
        .req   (req)
    );

    always_comb begin
        sel_word = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (req.idx == IDX_W'(i)) sel_word = regs_q[i];
        end
    end

    wrb_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .live_low (sel_word[BYTE_W-1:0]),
        .hold_q   (hold_q)
    );

    wrb_regfile u_regs (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .hold_q (hold_q),
        .regs_q (regs_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (req.rd) begin
            bus_rdata <= (req.half == HALF_UPPER) ? sel_word[WORD_W-1:BYTE_W] : hold_q;
        end else begin
            bus_rdata <= '0;
        end
    end

    assign ctrl_word      = regs_q[CTRL_IDX];
    assign data_a         = regs_q[1];
    assign data_b         = regs_q[2];
    assign ctrl_chan_a_en = ctrl_word[2];
    assign ctrl_invert    = ctrl_word[1];
    assign ctrl_step_x2   = ctrl_word[0];
endmodule

// File: rtl/wrb_checker.sv
module wrb_checker
    import wrb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [BYTE_W-1:0] bus_wdata,
    input logic [BYTE_W-1:0] bus_rdata,
    input logic [WORD_W-1:0] ctrl_word,
    input logic [WORD_W-1:0] data_a,
    input logic [WORD_W-1:0] data_b,
    input logic [BYTE_W-1:0] hold_q
);
    assert_upper_wr_no_commit_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_addr[0]) |=> ($stable(ctrl_word) && $stable(data_a) && $stable(data_b)));

    assert_lower_wr_commit_a_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'b011) |=> (data_a == {$past(hold_q), $past(bus_wdata)}));

    assert_ctrl_high_zero_R4: assert property (@(posedge clk) disable iff (rst)
        ctrl_word[WORD_W-1:CTRL_BITS] == '0);

    assert_upper_rd_b_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == 3'b100) |=>
        (bus_rdata == $past(data_b[WORD_W-1:BYTE_W]) && hold_q == $past(data_b[BYTE_W-1:0])));

    assert_lower_rd_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr[0]) |=> (bus_rdata == $past(hold_q)));

    assert_idle_rdata_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd) |=> (bus_rdata == '0));

    assert_both_strobes_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_wr) |=> (bus_rdata == '0));
endmodule

bind wide_reg_bridge wrb_checker i_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ctrl_word (ctrl_word),
    .data_a    (data_a),
    .data_b    (data_b),
    .hold_q    (hold_q)
);

// File: tb/test_wide_reg_bridge.sv
module test_wide_reg_bridge;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [15:0] ctrl_word, data_a, data_b;
    logic       ctrl_chan_a_en, ctrl_invert, ctrl_step_x2;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_reg[4];
    int m_hold;
    int m_rdata;

    always #4 clk = ~clk;

    wide_reg_bridge i_wide_reg_bridge (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctrl_word(ctrl_word),
        .data_a(data_a), .data_b(data_b), .ctrl_chan_a_en(ctrl_chan_a_en),
        .ctrl_invert(ctrl_invert), .ctrl_step_x2(ctrl_step_x2)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_step(input bit r, input bit wr, input bit rd, input int addr, input int wd);
        int idx;
        bit low;
        int nrd;
        idx = addr >> 1;
        low = addr[0];
        nrd = 0;
        if (r) begin
            m_reg = '{0, 0, 0, 0};
            m_hold = 0;
        end else if (wr) begin
            if (!low) m_hold = wd;
            else if (idx < 3) m_reg[idx] = ((m_hold << 8) | wd) & ((idx == 0) ? 32'h7 : 32'hFFFF);
        end else if (rd) begin
            if (!low) begin
                nrd    = (idx < 3) ? (m_reg[idx] >> 8) & 8'hFF : 0;
                m_hold = (idx < 3) ? m_reg[idx] & 8'hFF : 0;
            end else begin
                nrd = m_hold;
            end
        end
        m_rdata = nrd;
    endtask

    task automatic compare_all(input string tag);
        check(tag, "rdata", int'(bus_rdata), m_rdata);
        check(tag, "ctrl", int'(ctrl_word), m_reg[0]);
        check(tag, "data_a", int'(data_a), m_reg[1]);
        check(tag, "data_b", int'(data_b), m_reg[2]);
        check(tag, "ctrl bits", int'({ctrl_chan_a_en, ctrl_invert, ctrl_step_x2}), m_reg[0] & 7);
    endtask

    task automatic cyc(input string tag, input bit wr, input bit rd, input int addr, input int wd);
        @(negedge clk);
        bus_wr = wr;
        bus_rd = rd;
        bus_addr = 3'(addr);
        bus_wdata = 8'(wd);
        @(posedge clk);
        model_step(rst, wr, rd, addr, wd);
        #1;
        compare_all(tag);
    endtask

    task automatic wr16(input string tag, input int idx, input int val);
        cyc(tag, 1, 0, idx * 2, val >> 8);
        cyc(tag, 1, 0, idx * 2 + 1, val & 8'hFF);
    endtask

    task automatic rd16(input string tag, input int idx, input int exp);
        cyc(tag, 0, 1, idx * 2, 0);
        check(tag, "upper byte", int'(bus_rdata), (exp >> 8) & 8'hFF);
        cyc(tag, 0, 1, idx * 2 + 1, 0);
        check(tag, "lower byte", int'(bus_rdata), exp & 8'hFF);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset clears everything
        rst = 1'b1;
        cyc("R1", 1, 0, 1, 8'hAA);
        cyc("R1", 0, 1, 0, 0);
        rst = 1'b0;
        cyc("R1", 0, 0, 0, 0);

        // R2: upper write parks byte only
        cyc("R2", 1, 0, 2, 8'h12);
        check("R2", "data_a untouched", int'(data_a), 0);
        // R3: lower write commits whole word
        cyc("R3", 1, 0, 3, 8'h34);
        check("R3", "data_a commit", int'(data_a), 16'h1234);
        wr16("R3", 2, 16'hBEEF);
        check("R3", "data_b commit", int'(data_b), 16'hBEEF);

        // R5 / R6: reads through the holding register
        rd16("R5", 1, 16'h1234);
        rd16("R6", 2, 16'hBEEF);
        // R6: lower read returns captured byte, not live byte
        cyc("R6", 0, 1, 2, 0);
        cyc("R6", 1, 0, 3, 8'h99);
        check("R6", "live low changed", int'(data_a), 16'h3499);
        cyc("R6", 0, 1, 3, 0);
        check("R6", "lower read is held byte", int'(bus_rdata), 8'h34);

        // R4: control register keeps three bits
        wr16("R4", 0, 16'hFFFF);
        check("R4", "ctrl masked", int'(ctrl_word), 7);
        wr16("R4", 0, 16'h0005);
        check("R4", "enable/step bits", int'({ctrl_chan_a_en, ctrl_invert, ctrl_step_x2}), 3'b101);
        rd16("R4", 0, 16'h0005);

        // R7: cross-register combination via shared holding register
        cyc("R7", 1, 0, 2, 8'h5A);
        cyc("R7", 1, 0, 5, 8'hC3);
        check("R7", "data_b combined", int'(data_b), 16'h5AC3);
        check("R7", "data_a kept", int'(data_a), 16'h3499);
        cyc("R7", 0, 1, 4, 0);
        cyc("R7", 0, 1, 3, 0);
        check("R7", "read crosses registers", int'(bus_rdata), 8'hC3);

        // R8: idle and unused index
        cyc("R8", 0, 0, 0, 0);
        check("R8", "idle rdata", int'(bus_rdata), 0);
        cyc("R8", 0, 1, 6, 0);
        check("R8", "unused upper read", int'(bus_rdata), 0);
        cyc("R8", 0, 1, 7, 0);
        check("R8", "hold cleared by unused read", int'(bus_rdata), 0);
        cyc("R8", 1, 0, 7, 8'h77);

        // R9: both strobes -> write only
        cyc("R9", 1, 1, 2, 8'h44);
        check("R9", "rdata zero", int'(bus_rdata), 0);
        cyc("R9", 1, 1, 3, 8'h55);
        check("R9", "write happened", int'(data_a), 16'h4455);

        // Mixed free-running traffic against the model (R2 R3 R5 R6 R7 R8 R9)
        for (int n = 0; n < 600; n++) begin
            int sel;
            sel = $urandom_range(0, 3);
            cyc("R7", sel == 1 || sel == 3, sel >= 2, $urandom_range(0, 7), $urandom_range(0, 255));
        end

        // R1: reset in the middle clears state again
        rst = 1'b1;
        cyc("R1", 0, 0, 0, 0);
        rst = 1'b0;
        cyc("R1", 0, 1, 3, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule